// File: doc/BRIEF.md
# Timer Input Capture Channel

This block is one input-capture channel of a general-purpose timer, together with the free-running counter it samples. Two asynchronous input lines arrive: the channel's own input and the input of the neighbouring channel. A synchronous internal trigger also arrives. Each asynchronous line is brought into the clock domain by a two-flop synchronizer. It then passes a digital filter set by a 4-bit field, which rejects pulses shorter than a chosen number of samples.

The filtered lines feed edge detectors whose active edge is set by a polarity control. A source selector picks the event stream: the own line, the neighbour line or the trigger. An event divider passes every first, second, fourth or eighth event. On each event that passes, the counter value is latched into the capture register and a capture flag is set. If the flag was still set, an overcapture flag is set as well. The counter runs while enabled, and a software update request resets it to zero.

All configuration and status are plain pins. A capture cannot be stalled, so the block has no back-pressure path. Firmware or a surrounding register block must read the captured value before the next capture replaces it. The overcapture flag records that a value was lost.

Top module: `icap_channel`

## Requirements
- R1: While `cnt_en` is 1 the counter rises by one on every clock and wraps from all-ones to zero. While `cnt_en` is 0 it holds its value.
- R2: A one-cycle `ug_set` pulse sets `ug_bit` at the next clock edge. On the edge after that, `count` becomes 0 and `ug_bit` returns to 0, whatever the value of `cnt_en`.
- R3: Each asynchronous input passes two synchronizer flops and then the filter. With `flt_cfg` = 0 the filtered level follows the synchronized sample one clock later. With `flt_cfg` = N > 0 it changes only after 2N consecutive samples show the new level, so shorter pulses are dropped.
- R4: With `pol_fall` = 0 a rising edge of the filtered own or neighbour line is the active edge. With `pol_fall` = 1 a falling edge is the active edge.
- R5: `src_sel` selects the capture source: 2'b01 selects the own line, 2'b10 the neighbour line, and 2'b11 the trigger, where each cycle with `trig_in` high is one event and polarity does not apply. 2'b00 gives no events.
- R6: With `psc_sel` = k, a capture occurs on every 2^k-th event. The event count returns to zero while `cap_en` is 0 and in any cycle in which `psc_sel` differs from its value in the previous cycle.
- R7: On a capture, `cap_val` takes the `count` value held during the cycle of the event and `cap_flag` is set. A trigger pulse driven in the cycle where `count` is C captures C. An input-line change driven in that cycle captures C+3 when N = 0 and C+2+2N when N > 0.
- R8: A capture while `cap_flag` is already 1 also sets `ovr_flag`. When no capture occurs in the same cycle, `flag_clr` clears both flags.
- R9: While `cap_en` is 0 no capture happens: `cap_val`, `cap_flag` and `ovr_flag` keep their values.
- R10: After reset `count`, `cap_val`, `cap_flag`, `ovr_flag` and `ug_bit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer kernel clock, also the filter sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| ug_set | input | 1 | Software update-generation request (one-cycle strobe) |
| ti_own | input | 1 | Own asynchronous timer input |
| ti_nbr | input | 1 | Neighbour channel's asynchronous timer input |
| trig_in | input | 1 | Synchronous internal trigger event |
| flt_cfg | input | 4 | Filter length setting N |
| pol_fall | input | 1 | Active edge: 0 rising, 1 falling |
| src_sel | input | 2 | Capture source select |
| psc_sel | input | 2 | Event divider exponent k (divide by 2^k) |
| cap_en | input | 1 | Capture enable |
| flag_clr | input | 1 | Clear strobe for both flags |
| count | output | CNT_W | Free-running counter value |
| ug_bit | output | 1 | Pending update-generation bit, self-clearing |
| cap_val | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Capture flag |
| ovr_flag | output | 1 | Overcapture flag |

## Verification
The bench builds the channel with an 8-bit counter, so it can watch a full wrap of the counter within a few hundred cycles. The filter field keeps its full 4-bit width, so settings from zero to three exercise both the pass-through path and the 2N-sample path. The divider field also keeps its full width, which brings all four division ratios within reach, including the eight-event case on the trigger source.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int FLT_W = 4;
  localparam int PSC_W = 2;
  localparam int SRC_W = 2;
  localparam logic [SRC_W-1:0] SRC_NONE = 2'b00;
  localparam logic [SRC_W-1:0] SRC_OWN  = 2'b01;
  localparam logic [SRC_W-1:0] SRC_NBR  = 2'b10;
  localparam logic [SRC_W-1:0] SRC_TRIG = 2'b11;
endpackage

// File: rtl/icap_cond.sv
// Two-flop synchronizer followed by a 2N-sample agreement filter.
module icap_cond
  import icap_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [FLT_W-1:0] flt_cfg,
  output logic             dout
);
  localparam int FC_W = FLT_W + 1;

  logic [SYNC_N-1:0] sync_q;
  logic [FC_W-1:0]   agree_q;
  logic [FC_W-1:0]   need;
  logic              samp;

  assign samp = sync_q[SYNC_N-1];
  assign need = {flt_cfg, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= 1'b0;
      agree_q <= '0;
    end else if (flt_cfg == '0) begin
      dout    <= samp;
      agree_q <= '0;
    end else if (samp == dout) begin
      agree_q <= '0;
    end else if (agree_q + 1'b1 >= need) begin
      dout    <= samp;
      agree_q <= '0;
    end else begin
      agree_q <= agree_q + 1'b1;
    end
  end
endmodule

// File: rtl/icap_counter.sv
// Free-running counter with enable and self-clearing update request.
module icap_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             ug_set,
  output logic [CNT_W-1:0] count,
  output logic             ug_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      ug_bit <= 1'b0;
    end else begin
      ug_bit <= ug_set & ~ug_bit;
      if (ug_bit)      count <= '0;
      else if (cnt_en) count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/icap_evsel.sv
// Per-line edge detection with polarity, then source selection.
module icap_evsel
  import icap_pkg::*;
#(
  parameter int N_LINES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] filt,
  input  logic               trig_in,
  input  logic               pol_fall,
  input  logic [SRC_W-1:0]   src_sel,
  output logic               evt
);
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= filt;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_edge
    logic rise, fall;
    assign rise   = filt[g] & ~prev_q[g];
    assign fall   = ~filt[g] & prev_q[g];
    assign act[g] = pol_fall ? fall : rise;
  end

  always_comb begin
    case (src_sel)
      SRC_OWN:  evt = act[0];
      SRC_NBR:  evt = act[1];
      SRC_TRIG: evt = trig_in;
      default:  evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/icap_psc.sv
// Event divider: passes every 2^k-th event.
module icap_psc
  import icap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             cap_en,
  input  logic [PSC_W-1:0] psc_sel,
  output logic             fire
);
  localparam int DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] ev_q;
  logic [PSC_W-1:0] psc_q;
  logic [DIV_W-1:0] limit;
  logic             restart;

  assign limit   = DIV_W'((1 << psc_sel) - 1);
  assign restart = ~cap_en | (psc_sel != psc_q);
  assign fire    = evt & ~restart & (ev_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q  <= '0;
      psc_q <= '0;
    end else begin
      psc_q <= psc_sel;
      if (restart)   ev_q <= '0;
      else if (fire) ev_q <= '0;
      else if (evt)  ev_q <= ev_q + 1'b1;
    end
  end
endmodule

// File: rtl/icap_channel.sv
module icap_channel
  import icap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             ug_set,
  input  logic             ti_own,
  input  logic             ti_nbr,
  input  logic             trig_in,
  input  logic [3:0]       flt_cfg,
  input  logic             pol_fall,
  input  logic [1:0]       src_sel,
  input  logic [1:0]       psc_sel,
  input  logic             cap_en,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             ug_bit,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             ovr_flag
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw;
  logic [N_LINES-1:0] filt;
  logic               evt;
  logic               fire;

  assign raw = {ti_nbr, ti_own};

  icap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ug_set(ug_set),
    .count(count), .ug_bit(ug_bit)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_cond
    icap_cond u_cond (
      .clk(clk), .rst_n(rst_n), .din(raw[g]), .flt_cfg(flt_cfg), .dout(filt[g])
    );
  end

  icap_evsel #(.N_LINES(N_LINES)) u_sel (
    .clk(clk), .rst_n(rst_n), .filt(filt), .trig_in(trig_in),
    .pol_fall(pol_fall), .src_sel(src_sel), .evt(evt)
  );

  icap_psc u_psc (
    .clk(clk), .rst_n(rst_n), .evt(evt), .cap_en(cap_en),
    .psc_sel(psc_sel), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else if (fire) begin
      cap_val  <= count;
      cap_flag <= 1'b1;
      if (cap_flag) ovr_flag <= 1'b1;
    end else if (flag_clr) begin
      cap_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             ug_bit,
  input logic [CNT_W-1:0] count,
  input logic             cap_en,
  input logic [1:0]       src_sel,
  input logic [1:0]       psc_sel,
  input logic             trig_in,
  input logic             flag_clr,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_flag,
  input logic             ovr_flag
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !ug_bit) |=> count == $past(count) + CNT_W'(1)); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !ug_bit) |=> $stable(count)); // R1
  AST_UG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ug_bit |=> (count == '0) && !ug_bit); // R2
  AST_TRIG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b11 && trig_in && cap_en && psc_sel == 2'b00 && $stable(psc_sel)) |=> cap_flag); // R5
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> cap_val == $past(count)); // R7
  AST_OVR_NEEDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> cap_flag); // R8
  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_en) |=> !cap_flag && !ovr_flag); // R8
  AST_NO_CAP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(cap_val)); // R9
endmodule

bind icap_channel icap_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ug_bit(ug_bit), .count(count),
  .cap_en(cap_en), .src_sel(src_sel), .psc_sel(psc_sel), .trig_in(trig_in),
  .flag_clr(flag_clr), .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag)
);

// File: tb/icap_channel_tb.sv
module icap_channel_tb;
  localparam int CW = 8;
  localparam int NV = 11;
  // {src[2], pol[1], flt[4], psc[2], line[2], edges[4], expect[1]}
  localparam logic [15:0] VEC [NV] = '{
    {2'd1, 1'b0, 4'd0, 2'd0, 2'd0, 4'd1, 1'b1},
    {2'd1, 1'b1, 4'd0, 2'd0, 2'd0, 4'd1, 1'b1},
    {2'd1, 1'b0, 4'd3, 2'd0, 2'd0, 4'd1, 1'b1},
    {2'd2, 1'b0, 4'd1, 2'd0, 2'd1, 4'd1, 1'b1},
    {2'd3, 1'b0, 4'd0, 2'd0, 2'd2, 4'd1, 1'b1},
    {2'd1, 1'b0, 4'd0, 2'd2, 2'd0, 4'd4, 1'b1},
    {2'd1, 1'b0, 4'd0, 2'd2, 2'd0, 4'd3, 1'b0},
    {2'd1, 1'b0, 4'd0, 2'd1, 2'd1, 4'd2, 1'b0},
    {2'd0, 1'b0, 4'd0, 2'd0, 2'd0, 4'd1, 1'b0},
    {2'd3, 1'b0, 4'd0, 2'd3, 2'd2, 4'd8, 1'b1},
    {2'd2, 1'b1, 4'd2, 2'd1, 2'd1, 4'd2, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 1'b0, ug_set = 1'b0, ti_own = 1'b0, ti_nbr = 1'b0, trig_in = 1'b0;
  logic [3:0] flt_cfg = '0;
  logic pol_fall = 1'b0, cap_en = 1'b0, flag_clr = 1'b0;
  logic [1:0] src_sel = '0, psc_sel = '0;
  logic [CW-1:0] count, cap_val;
  logic ug_bit, cap_flag, ovr_flag;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  icap_channel #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ug_set(ug_set), .ti_own(ti_own),
    .ti_nbr(ti_nbr), .trig_in(trig_in), .flt_cfg(flt_cfg), .pol_fall(pol_fall),
    .src_sel(src_sel), .psc_sel(psc_sel), .cap_en(cap_en), .flag_clr(flag_clr),
    .count(count), .ug_bit(ug_bit), .cap_val(cap_val), .cap_flag(cap_flag),
    .ovr_flag(ovr_flag)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_line(input int line, input logic v);
    if (line == 0) ti_own = v;
    else if (line == 1) ti_nbr = v;
  endtask

  // Drive one active edge on the chosen line, return count at drive time.
  task automatic pulse(input int line, input logic pol, input int flt, output logic [CW-1:0] c);
    int hold;
    hold = 2 * flt + 4;
    if (line == 2) begin
      trig_in = 1'b1; c = count; step(1); trig_in = 1'b0; step(3);
    end else begin
      set_line(line, ~pol); c = count; step(hold);
      set_line(line, pol);  step(hold);
    end
  endtask

  task automatic run_vec(input logic [15:0] v, input int idx);
    logic [1:0] src, psc, line;
    logic pol, exp;
    logic [3:0] flt, nedge;
    logic [CW-1:0] c, want;
    {src, pol, flt, psc, line, nedge, exp} = v;
    cap_en = 1'b0; src_sel = src; pol_fall = pol; flt_cfg = flt; psc_sel = psc;
    ti_own = pol; ti_nbr = pol; trig_in = 1'b0; flag_clr = 1'b1;
    step(1); flag_clr = 1'b0;
    step(2 * int'(flt) + 6);
    cap_en = 1'b1; step(2);
    c = '0;
    for (int i = 0; i < int'(nedge); i++) pulse(int'(line), pol, int'(flt), c);
    if (line == 2) want = c;
    else want = c + CW'(2) + ((flt == 0) ? CW'(1) : CW'(2 * int'(flt)));
    $display("vector %0d", idx);
    chk("R4 R5 R6 flag", int'(cap_flag), int'(exp));
    if (exp) chk("R3 R7 value", int'(cap_val), int'(want));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] c0, c1;
    step(3);
    // R10 reset state
    chk("R10 count", int'(count), 0);
    chk("R10 cap_val", int'(cap_val), 0);
    chk("R10 flags", int'({cap_flag, ovr_flag, ug_bit}), 0);
    rst_n = 1'b1; step(2);
    // R1 hold while disabled
    c0 = count; step(5);
    chk("R1 hold", int'(count), int'(c0));
    cnt_en = 1'b1; step(1); c0 = count; step(5);
    chk("R1 step", int'(count), int'(c0 + CW'(5)));
    c0 = count; step(256);
    chk("R1 wrap", int'(count), int'(c0));
    // R2 update generation
    ug_set = 1'b1; step(1); ug_set = 1'b0;
    chk("R2 ug_bit set", int'(ug_bit), 1);
    step(1);
    chk("R2 count zero", int'(count), 0);
    chk("R2 ug_bit clear", int'(ug_bit), 0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R3 short pulse rejected with flt=2, then a long one accepted
    cap_en = 1'b0; src_sel = 2'b01; pol_fall = 1'b0; flt_cfg = 4'd2; psc_sel = 2'd0;
    ti_own = 1'b0; flag_clr = 1'b1; step(1); flag_clr = 1'b0; step(10);
    cap_en = 1'b1; step(2);
    ti_own = 1'b1; step(2); ti_own = 1'b0; step(10);
    chk("R3 glitch ignored", int'(cap_flag), 0);
    ti_own = 1'b1; c0 = count; step(10); ti_own = 1'b0; step(8);
    chk("R3 long pulse", int'(cap_val), int'(c0 + CW'(6)));

    // R6 divider restart on field change
    cap_en = 1'b0; src_sel = 2'b11; psc_sel = 2'd1; flag_clr = 1'b1; step(1);
    flag_clr = 1'b0; cap_en = 1'b1; step(2);
    pulse(2, 1'b0, 0, c0);
    psc_sel = 2'd2; step(2);
    for (int i = 0; i < 3; i++) pulse(2, 1'b0, 0, c0);
    chk("R6 restart no capture", int'(cap_flag), 0);
    pulse(2, 1'b0, 0, c1);
    chk("R6 fourth event", int'(cap_val), int'(c1));

    // R8 overcapture and clear
    psc_sel = 2'd0; step(2);
    pulse(2, 1'b0, 0, c0);
    chk("R8 ovr set", int'(ovr_flag), 1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R8 clear", int'({cap_flag, ovr_flag}), 0);
    pulse(2, 1'b0, 0, c0);
    chk("R8 single capture", int'({cap_flag, ovr_flag}), 2);

    // R9 disabled channel ignores events
    c1 = cap_val; cap_en = 1'b0; step(1);
    pulse(2, 1'b0, 0, c0);
    chk("R9 value kept", int'(cap_val), int'(c1));
    chk("R9 flags kept", int'({cap_flag, ovr_flag}), 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule